// File: doc/BRIEF.md
# Prefix Remap and Low-Address Store Guard

This block sits on the physical side of an address pipeline, after any page translation. It takes one real address per request and returns the absolute address. The first 8 KiB of real storage trade places with an 8 KiB prefix area: low addresses move up into the prefix area, and prefix-area addresses move down to zero. All other addresses pass through unchanged.

The block also guards a store-only protection window. The window covers the first 512 bytes of each of the two lowest 4 KiB pages. Whether the window is live depends on a global enable. When translation is on, it also depends on the private flag of the active address space. Any access whose page base lies in the low 8 KiB while the guard is live raises a write-invalidate hint, so that a cached write permission for that page is never reused. A store that hits the window returns a protection fault and no address. An unsupported space mode with translation on returns a mode error.

Control is a two-state machine. `ST_IDLE` accepts a request. Transition `take` (valid while idle) registers the result and enters `ST_HOLD`. `ST_HOLD` presents the response. Transition `release` (response ready) returns to `ST_IDLE`.

Top module: `prefix_lowprot_unit`

## Requirements
- R1: A real address below 0x2000 maps to that address plus the aligned prefix.
- R2: An address `a` with aligned prefix `p`, where `p <= a < p + 0x2000`, maps to `a - p`. R1 takes precedence over this rule. Every other address passes through unchanged.
- R3: The low 13 bits of `prefix` are ignored. The aligned prefix is `prefix` with those bits cleared.
- R4: The store window is bytes 0..511 and 4096..4607, both inclusive. A store (`req_kind` = 1) into the window while the guard is live gives `rsp_prot_fault` = 1 and `rsp_abs_addr` = 0. A store at 512..4095 or at 4608 and above does not fault.
- R5: Reads (`req_kind` = 0), fetches (`req_kind` = 2) and code 3 (handled as a read) never fault.
- R6: With `xlate_on` = 1, the guard is live only if `lap_en` = 1 and the private flag of the selected space is 0. The space encoding is `space_mode` 0 = primary, 1 = secondary, 2 = home.
- R7: With `xlate_on` = 0, the guard is live exactly when `lap_en` = 1. `space_mode` and all private flags have no effect.
- R8: `rsp_wr_inval` = 1 exactly when the guard is live and the address is below 0x2000, whatever the access kind. This includes addresses that do not fault.
- R9: With `xlate_on` = 1 and `space_mode` = 3, the response is `rsp_mode_err` = 1 with fault, hint and address all 0.
- R10: `req_ready` is 1 only in `ST_IDLE`. A request accepted at an edge appears on `rsp_valid` after that edge. The response holds stable until an edge with `rsp_ready` = 1.
- R11: After reset, `rsp_valid` = 0 and `req_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W | Real address |
| req_kind | input | 2 | 0 read, 1 store, 2 fetch, 3 handled as read |
| prefix | input | ADDR_W | Prefix value (low 13 bits ignored) |
| lap_en | input | 1 | Global low-address guard enable |
| xlate_on | input | 1 | Translation active |
| space_mode | input | 2 | 0 primary, 1 secondary, 2 home, 3 unsupported |
| priv_primary | input | 1 | Private flag of the primary space |
| priv_secondary | input | 1 | Private flag of the secondary space |
| priv_home | input | 1 | Private flag of the home space |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_abs_addr | output | ADDR_W | Absolute address |
| rsp_wr_inval | output | 1 | Write-invalidate hint for the page |
| rsp_prot_fault | output | 1 | Protection fault |
| rsp_mode_err | output | 1 | Unsupported space mode |

## Verification
The assertions check on every cycle these properties:
- a fault carries a zero address and the invalidate hint;
- only a captured store can fault;
- a mode error excludes every other result;
- an accepted request produces a response on the next cycle;
- a stalled response stays frozen.

The address arithmetic of the two remap windows, the prefix alignment, and the exact edges of the store window (511/512, 4607/4608) can only be shown by the bench's scenarios, which compare each result against a behavioural model. The same holds for which private flag each space selects.

// File: rtl/plap_pkg.sv
package plap_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } access_kind_e;

    typedef enum logic [1:0] {
        SP_PRIMARY   = 2'd0,
        SP_SECONDARY = 2'd1,
        SP_HOME      = 2'd2,
        SP_UNSUP     = 2'd3
    } space_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } fsm_e;
endpackage

// File: rtl/plap_remap.sv
module plap_remap #(
    parameter int ADDR_W   = 64,
    parameter int WIN_BITS = 13
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] prefix,
    output logic [ADDR_W-1:0] abs_addr
);
    localparam int HI_W = ADDR_W - WIN_BITS;

    logic [ADDR_W-1:0] pre_al;
    logic              in_low;
    logic              in_pre;

    always_comb begin
        pre_al = {prefix[ADDR_W-1:WIN_BITS], {WIN_BITS{1'b0}}};
        in_low = (addr[ADDR_W-1:WIN_BITS] == {HI_W{1'b0}});
        in_pre = (addr[ADDR_W-1:WIN_BITS] == prefix[ADDR_W-1:WIN_BITS]);
        if (in_low)
            abs_addr = addr + pre_al;
        else if (in_pre)
            abs_addr = addr - pre_al;
        else
            abs_addr = addr;
    end
endmodule

// File: rtl/plap_guard.sv
module plap_guard import plap_pkg::*; #(
    parameter int ADDR_W     = 64,
    parameter int PAGE_BITS  = 12,
    parameter int PROT_BYTES = 512
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        kind,
    input  logic              xlate_on,
    input  logic              lap_en,
    input  logic [1:0]        space_mode,
    input  logic              priv_primary,
    input  logic              priv_secondary,
    input  logic              priv_home,
    output logic              inval,
    output logic              fault,
    output logic              mode_err
);
    localparam int WIN_BITS = PAGE_BITS + 1;
    localparam int HI_W     = ADDR_W - WIN_BITS;
    localparam logic [PAGE_BITS-1:0] OFF_LIM = PAGE_BITS'(PROT_BYTES);

    logic priv_sel;
    logic space_ok;
    logic live;
    logic page_low;
    logic off_low;
    logic is_store;

    always_comb begin
        priv_sel = 1'b0;
        space_ok = 1'b1;
        unique case (space_e'(space_mode))
            SP_PRIMARY:   priv_sel = priv_primary;
            SP_SECONDARY: priv_sel = priv_secondary;
            SP_HOME:      priv_sel = priv_home;
            SP_UNSUP:     space_ok = 1'b0;
            default:      space_ok = 1'b0;
        endcase
    end

    always_comb begin
        mode_err = xlate_on && !space_ok;
        if (!xlate_on)
            live = lap_en;
        else
            live = lap_en && space_ok && !priv_sel;
        page_low = (addr[ADDR_W-1:WIN_BITS] == {HI_W{1'b0}});
        off_low  = (addr[PAGE_BITS-1:0] < OFF_LIM);
        is_store = (access_kind_e'(kind) == ACC_STORE);
        inval    = live && page_low;
        fault    = live && page_low && off_low && is_store;
    end
endmodule

// File: rtl/prefix_lowprot_unit.sv
module prefix_lowprot_unit import plap_pkg::*; #(
    parameter int ADDR_W     = 64,
    parameter int PAGE_BITS  = 12,
    parameter int PROT_BYTES = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] prefix,
    input  logic              lap_en,
    input  logic              xlate_on,
    input  logic [1:0]        space_mode,
    input  logic              priv_primary,
    input  logic              priv_secondary,
    input  logic              priv_home,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_abs_addr,
    output logic              rsp_wr_inval,
    output logic              rsp_prot_fault,
    output logic              rsp_mode_err
);
    localparam int WIN_BITS = PAGE_BITS + 1;

    fsm_e              state_q, state_d;
    logic              take;
    logic [ADDR_W-1:0] remap_addr;
    logic              g_inval, g_fault, g_mode_err;
    logic [ADDR_W-1:0] nxt_addr;
    logic              nxt_inval, nxt_fault, nxt_mode_err;

    plap_remap #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_remap (
        .addr     (req_addr),
        .prefix   (prefix),
        .abs_addr (remap_addr)
    );

    plap_guard #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .PROT_BYTES(PROT_BYTES)) u_guard (
        .addr           (req_addr),
        .kind           (req_kind),
        .xlate_on       (xlate_on),
        .lap_en         (lap_en),
        .space_mode     (space_mode),
        .priv_primary   (priv_primary),
        .priv_secondary (priv_secondary),
        .priv_home      (priv_home),
        .inval          (g_inval),
        .fault          (g_fault),
        .mode_err       (g_mode_err)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_HOLD;
            ST_HOLD: if (rsp_ready) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign req_ready = (state_q == ST_IDLE);
    assign rsp_valid = (state_q == ST_HOLD);
    assign take      = req_valid && req_ready;

    always_comb begin
        if (g_mode_err) begin
            nxt_addr     = '0;
            nxt_inval    = 1'b0;
            nxt_fault    = 1'b0;
            nxt_mode_err = 1'b1;
        end else begin
            nxt_addr     = g_fault ? '0 : remap_addr;
            nxt_inval    = g_inval;
            nxt_fault    = g_fault;
            nxt_mode_err = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_abs_addr   <= '0;
            rsp_wr_inval   <= 1'b0;
            rsp_prot_fault <= 1'b0;
            rsp_mode_err   <= 1'b0;
        end else if (take) begin
            rsp_abs_addr   <= nxt_addr;
            rsp_wr_inval   <= nxt_inval;
            rsp_prot_fault <= nxt_fault;
            rsp_mode_err   <= nxt_mode_err;
        end
    end
endmodule

// File: rtl/plap_checker.sv
module plap_checker #(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_kind,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [ADDR_W-1:0] rsp_abs_addr,
    input logic              rsp_wr_inval,
    input logic              rsp_prot_fault,
    input logic              rsp_mode_err
);
    logic [1:0] kind_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      kind_q <= 2'd0;
        else if (req_valid && req_ready) kind_q <= req_kind;
    end

    a_r4_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_prot_fault |-> rsp_abs_addr == '0 && rsp_wr_inval);

    a_r5_fault_only_store: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_prot_fault |-> kind_q == 2'd1);

    a_r9_mode_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_mode_err |-> !rsp_prot_fault && !rsp_wr_inval && rsp_abs_addr == '0);

    a_r10_accept_next: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> rsp_valid);

    a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_abs_addr)
            && $stable(rsp_prot_fault) && $stable(rsp_wr_inval) && $stable(rsp_mode_err));
endmodule

bind prefix_lowprot_unit plap_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_prefix_lowprot_unit.sv
module tb_prefix_lowprot_unit;
    localparam int  AW      = 64;
    localparam time CLK_PER = 10ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_kind = 2'd0;
    logic [AW-1:0] prefix = '0;
    logic          lap_en = 1'b0;
    logic          xlate_on = 1'b0;
    logic [1:0]    space_mode = 2'd0;
    logic          priv_primary = 1'b0;
    logic          priv_secondary = 1'b0;
    logic          priv_home = 1'b0;
    logic          rsp_valid;
    logic          rsp_ready = 1'b0;
    logic [AW-1:0] rsp_abs_addr;
    logic          rsp_wr_inval;
    logic          rsp_prot_fault;
    logic          rsp_mode_err;

    int    n_checks = 0;
    int    n_fails  = 0;
    string cur_req  = "R11";
    bit    done     = 0;

    // behavioural reference state
    bit          m_valid = 0;
    logic [AW-1:0] m_addr = '0;
    bit          m_inval = 0, m_fault = 0, m_merr = 0;

    always #(CLK_PER/2) clk = ~clk;

    prefix_lowprot_unit dut (.*);

    task automatic calc(output logic [AW-1:0] a, output bit inv, output bit flt, output bit me);
        logic [AW-1:0] pre;
        bit live;
        bit low;
        pre = prefix & ~64'h1FFF;
        me = 0;
        if (xlate_on) begin
            case (space_mode)
                2'd0: live = lap_en && !priv_primary;
                2'd1: live = lap_en && !priv_secondary;
                2'd2: live = lap_en && !priv_home;
                default: begin live = 0; me = 1; end
            endcase
        end else live = lap_en;
        if (req_addr < 64'h2000)                                    a = req_addr + pre;
        else if (req_addr >= pre && (req_addr - pre) < 64'h2000)    a = req_addr - pre;
        else                                                        a = req_addr;
        low = (req_addr <= 511) || (req_addr >= 4096 && req_addr <= 4607);
        inv = live && (req_addr < 64'h2000);
        flt = live && low && (req_kind == 2'd1);
        if (flt) a = '0;
        if (me) begin a = '0; inv = 0; flt = 0; end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_valid <= 0;
        else if (!m_valid && req_valid) begin
            logic [AW-1:0] a; bit i, f, e;
            calc(a, i, f, e);
            m_valid <= 1; m_addr <= a; m_inval <= i; m_fault <= f; m_merr <= e;
        end else if (m_valid && rsp_ready) m_valid <= 0;
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_checks++;
            if (rsp_valid !== m_valid || req_ready !== !m_valid) begin
                n_fails++;
                $display("FAIL %s: valid/ready got %b/%b expected %b/%b", cur_req,
                         rsp_valid, req_ready, m_valid, !m_valid);
            end else if (m_valid && (rsp_abs_addr !== m_addr || rsp_wr_inval !== m_inval ||
                         rsp_prot_fault !== m_fault || rsp_mode_err !== m_merr)) begin
                n_fails++;
                $display("FAIL %s: addr=%h inv=%b flt=%b merr=%b expected addr=%h inv=%b flt=%b merr=%b",
                         cur_req, rsp_abs_addr, rsp_wr_inval, rsp_prot_fault, rsp_mode_err,
                         m_addr, m_inval, m_fault, m_merr);
            end
        end
    end

    task automatic send(input string tag, input logic [AW-1:0] a, input logic [1:0] k,
                        input int stall);
        cur_req = tag;
        @(negedge clk);
        req_addr = a; req_kind = k; req_valid = 1'b1; rsp_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < stall; i++) @(negedge clk);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    task automatic cfg(input bit xl, input bit lap, input logic [1:0] sp,
                       input bit pp, input bit ps, input bit ph);
        xlate_on = xl; lap_en = lap; space_mode = sp;
        priv_primary = pp; priv_secondary = ps; priv_home = ph;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R11";
        repeat (3) @(negedge clk);

        prefix = 64'h0000_0000_0012_4000;
        cfg(0, 0, 2'd0, 0, 0, 0);
        send("R1", 64'h1234, 2'd0, 0);
        send("R1", 64'h0, 2'd2, 0);
        send("R2", 64'h125008, 2'd0, 0);
        send("R2", 64'h126000, 2'd0, 0);
        send("R2", 64'h123FFF, 2'd1, 0);
        send("R2", 64'hFFFF_0000_0000_0010, 2'd0, 0);

        prefix = 64'h0000_0000_0012_5ABC;
        send("R3", 64'h10, 2'd0, 0);
        send("R3", 64'h125ABC, 2'd0, 0);

        cfg(0, 1, 2'd0, 0, 0, 0);
        send("R4", 64'h1FF, 2'd1, 0);
        send("R4", 64'h1000, 2'd1, 0);
        send("R4", 64'h11FF, 2'd1, 0);
        send("R4", 64'h200, 2'd1, 0);
        send("R4", 64'h1200, 2'd1, 0);
        send("R4", 64'h3000, 2'd1, 0);

        send("R5", 64'h0, 2'd0, 0);
        send("R5", 64'h1100, 2'd2, 0);
        send("R5", 64'h10, 2'd3, 0);

        cfg(1, 1, 2'd1, 0, 1, 0);
        send("R6", 64'h10, 2'd1, 0);
        cfg(1, 1, 2'd1, 1, 0, 1);
        send("R6", 64'h10, 2'd1, 0);
        cfg(1, 1, 2'd2, 0, 0, 1);
        send("R6", 64'h1010, 2'd1, 0);
        cfg(1, 1, 2'd0, 0, 1, 1);
        send("R6", 64'h1010, 2'd1, 0);
        cfg(1, 0, 2'd0, 0, 0, 0);
        send("R6", 64'h10, 2'd1, 0);

        cfg(0, 1, 2'd3, 1, 1, 1);
        send("R7", 64'h10, 2'd1, 0);
        cfg(0, 0, 2'd0, 0, 0, 0);
        send("R7", 64'h10, 2'd1, 0);

        cfg(0, 1, 2'd0, 0, 0, 0);
        send("R8", 64'h0FFF, 2'd0, 0);
        send("R8", 64'h2000, 2'd1, 0);

        cfg(1, 1, 2'd3, 0, 0, 0);
        send("R9", 64'h10, 2'd1, 0);
        send("R9", 64'h5000, 2'd0, 0);

        cfg(0, 1, 2'd0, 0, 0, 0);
        send("R10", 64'h1F0, 2'd1, 3);
        send("R10", 64'h126004, 2'd0, 2);
        send("R10", 64'h8000, 2'd2, 1);

        cur_req = "R11";
        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule